// File: doc/BRIEF.md
# Strobed Control Register Latch Bank

This block receives writes from a host over a shared 8-bit parallel data bus and holds three 8-bit control registers: a system control register, a monitor routing register and a clock/routing register. Each register has its own active-low select strobe. A shared active-low output enable and a read/write line qualify every write. The host places data on the bus, pulls the output enable low, pulses the chosen strobe low and then releases it. The register captures the bus on that release, and the host then returns the bus to all-ones.

All bus-side inputs are asynchronous to the system clock. Data, enable, read/write and strobes pass together through one synchronizer of `SYNC_STAGES` flops, so they stay aligned. A strobe release is found as a rising edge of the synchronized strobe. The clock/routing register is also decoded continuously into a sample-rate index, a clock-source code and an invalid-configuration flag.

Top module: `strobe_latch_bank`

## Requirements
- R1: After reset, all three registers read 0x00, `clk_src` is 0 (internal), `rate_idx` is 0 and `cfg_invalid` is 0.
- R2: With `oe_n`=0 and `rw`=0, the release (low-to-high) of `strb_n[i]` stores `bus_d` into register i. Index 0 is the system register, 1 is the monitor register and 2 is the clock register. The new value appears at the outputs on the third rising clock edge after the release, with the default of two synchronizer stages.
- R3: A strobe release while `rw`=1 (read) leaves every register unchanged.
- R4: A strobe release while `oe_n`=1 leaves every register unchanged.
- R5: A register changes only on its own strobe's release. A falling strobe, or a strobe held low while the bus changes, writes nothing. The value captured is the bus value present at the release.
- R6: When clock register bit 3 is 0, `rate_idx` equals bits [2:0]. The codes are 0=44.1k, 1=48k, 2=88.2k, 3=96k, 4=176.4k and 5=192k. When bit 3 is 1, `rate_idx` is 0.
- R7: `clk_src` is 0 when bit 3 is 0. When bit 3 is 1, it is decoded from bits [4:0]: 0x08 gives 1 (S/PDIF), 0x0A gives 2 (word clock 1xFS) and 0x1A gives 3 (word clock 256xFS). Any other external code gives 0.
- R8: `cfg_invalid` is 1 exactly when bit 3 is 0 with bits [2:0] equal to 6 or 7, or when bit 3 is 1 with bits [4:0] not one of 0x08, 0x0A or 0x1A.
- R9: Strobes released together with the same qualifiers each store the same bus value into their own register.
- R10: Every register output shows the full stored byte. The clock register's bits 5 to 7 are kept and do not affect the decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_d | input | 8 | Shared parallel data bus |
| oe_n | input | 1 | Shared output enable, active low |
| rw | input | 1 | 0 = write, 1 = read |
| strb_n | input | 3 | Register select strobes, active low (0 system, 1 monitor, 2 clock) |
| sys_reg | output | 8 | System control register |
| mon_reg | output | 8 | Monitor routing register |
| clk_reg | output | 8 | Clock/routing register |
| rate_idx | output | 3 | Decoded internal sample-rate index |
| clk_src | output | 2 | Decoded clock source (0 internal, 1 S/PDIF, 2 WC 1xFS, 3 WC 256xFS) |
| cfg_invalid | output | 1 | Clock register holds an unsupported code |

## Verification
The bench looks for several kinds of internal fault. A misaligned synchronizer would latch the all-ones idle bus instead of the intended byte. A wrong edge detector would show up as a register that changes while its strobe is still low. A broken qualifier would let a write through during a read or while the enable is high. Each of these faults is visible at the register outputs three clock edges after the strobe release. The bench checks every register after every access. It sweeps all 256 clock register values, so any decode slip shows on `rate_idx`, `clk_src` or `cfg_invalid` in the same cycle the register updates.

// File: rtl/strb_bank_pkg.sv
package strb_bank_pkg;

  typedef enum logic [1:0] {
    SRC_INT   = 2'd0,
    SRC_SPDIF = 2'd1,
    SRC_WC1X  = 2'd2,
    SRC_WC256 = 2'd3
  } clk_src_e;

  typedef struct packed {
    logic [2:0] rate;
    clk_src_e   src;
    logic       bad;
  } clk_dec_t;

  localparam logic [4:0] CODE_SPDIF = 5'h08;
  localparam logic [4:0] CODE_WC1X  = 5'h0A;
  localparam logic [4:0] CODE_WC256 = 5'h1A;
  localparam logic [2:0] RATE_MAX   = 3'd5;

  // Decode the clock/routing byte: bit 3 picks internal vs external sync.
  function automatic clk_dec_t decode_clk(input logic [7:0] v);
    clk_dec_t r;
    r.rate = 3'd0;
    r.src  = SRC_INT;
    r.bad  = 1'b0;
    if (!v[3]) begin
      r.rate = v[2:0];
      r.bad  = (v[2:0] > RATE_MAX);
    end else begin
      unique case (v[4:0])
        CODE_SPDIF: r.src = SRC_SPDIF;
        CODE_WC1X:  r.src = SRC_WC1X;
        CODE_WC256: r.src = SRC_WC256;
        default:    r.bad = 1'b1;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/in_sync.sv
module in_sync #(
  parameter int          W       = 8,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) st[k] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/rise_det.sv
module rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
endmodule

// File: rtl/reg_slot.sv
module reg_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/clk_decode.sv
module clk_decode
  import strb_bank_pkg::*;
(
  input  logic [7:0] cfg,
  output logic [2:0] rate,
  output logic [1:0] src,
  output logic       bad
);
  clk_dec_t dec;

  always_comb begin
    dec  = decode_clk(cfg);
    rate = dec.rate;
    src  = dec.src;
    bad  = dec.bad;
  end
endmodule

// File: rtl/strobe_latch_bank.sv
module strobe_latch_bank #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_d,
  input  logic              oe_n,
  input  logic              rw,
  input  logic [2:0]        strb_n,
  output logic [DATA_W-1:0] sys_reg,
  output logic [DATA_W-1:0] mon_reg,
  output logic [DATA_W-1:0] clk_reg,
  output logic [2:0]        rate_idx,
  output logic [1:0]        clk_src,
  output logic              cfg_invalid
);
  localparam int NUM_REGS = 3;
  localparam int CTRL_W   = NUM_REGS + 2;
  localparam int PIPE_W   = DATA_W + CTRL_W;
  localparam logic [PIPE_W-1:0] PIPE_RST = {{CTRL_W{1'b1}}, {DATA_W{1'b0}}};

  logic [PIPE_W-1:0]          sync_q;
  logic [DATA_W-1:0]          data_q;
  logic [NUM_REGS-1:0]        strb_q;
  logic                       rw_q;
  logic                       oe_q;
  logic [NUM_REGS-1:0]        edge_seen;
  logic [NUM_REGS-1:0]        wr_pulse;
  logic [NUM_REGS*DATA_W-1:0] regs_flat;

  // Bus, qualifiers and strobes share one synchronizer so they stay aligned.
  in_sync #(.W(PIPE_W), .STAGES(SYNC_STAGES), .RST_VAL(PIPE_RST)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({oe_n, rw, strb_n, bus_d}),
    .q    (sync_q)
  );

  assign data_q = sync_q[DATA_W-1:0];
  assign strb_q = sync_q[DATA_W +: NUM_REGS];
  assign rw_q   = sync_q[DATA_W + NUM_REGS];
  assign oe_q   = sync_q[PIPE_W-1];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    rise_det u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (strb_q[i]),
      .rise (edge_seen[i])
    );

    assign wr_pulse[i] = edge_seen[i] & ~oe_q & ~rw_q;

    reg_slot #(.W(DATA_W)) u_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (wr_pulse[i]),
      .d    (data_q),
      .q    (regs_flat[i*DATA_W +: DATA_W])
    );
  end

  assign sys_reg = regs_flat[0*DATA_W +: DATA_W];
  assign mon_reg = regs_flat[1*DATA_W +: DATA_W];
  assign clk_reg = regs_flat[2*DATA_W +: DATA_W];

  clk_decode u_dec (
    .cfg (clk_reg[7:0]),
    .rate(rate_idx),
    .src (clk_src),
    .bad (cfg_invalid)
  );
endmodule

// File: rtl/latch_bank_chk.sv
module latch_bank_chk #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_REGS-1:0]        edge_seen,
  input logic [NUM_REGS-1:0]        wr_pulse,
  input logic                       rw_q,
  input logic                       oe_q,
  input logic [DATA_W-1:0]          data_q,
  input logic [NUM_REGS*DATA_W-1:0] regs_flat,
  input logic [DATA_W-1:0]          clk_reg,
  input logic [2:0]                 rate_idx,
  input logic [1:0]                 clk_src,
  input logic                       cfg_invalid
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_pulse[i] |=> $stable(regs_flat[i*DATA_W +: DATA_W]));

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse[i] |=> regs_flat[i*DATA_W +: DATA_W] == $past(data_q));

    assert_read_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_seen[i] && rw_q) |=> $stable(regs_flat[i*DATA_W +: DATA_W]));

    assert_oe_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_seen[i] && oe_q) |=> $stable(regs_flat[i*DATA_W +: DATA_W]));
  end

  assert_ext_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_src != 2'd0) |-> clk_reg[3]);

  assert_ext_rate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clk_reg[3] |-> rate_idx == 3'd0);

  assert_bad_rate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_reg[3] && clk_reg[2:1] == 2'b11) |-> cfg_invalid);

  assert_good_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_src != 2'd0) |-> !cfg_invalid);
endmodule

bind strobe_latch_bank latch_bank_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .edge_seen  (edge_seen),
  .wr_pulse   (wr_pulse),
  .rw_q       (rw_q),
  .oe_q       (oe_q),
  .data_q     (data_q),
  .regs_flat  (regs_flat),
  .clk_reg    (clk_reg),
  .rate_idx   (rate_idx),
  .clk_src    (clk_src),
  .cfg_invalid(cfg_invalid)
);

// File: tb/strobe_latch_bank_tb.sv
module strobe_latch_bank_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_d = 8'hFF;
  logic       oe_n = 1'b1;
  logic       rw = 1'b0;
  logic [2:0] strb_n = 3'b111;
  logic [7:0] sys_reg, mon_reg, clk_reg;
  logic [2:0] rate_idx;
  logic [1:0] clk_src;
  logic       cfg_invalid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_r [3];

  always #2 clk = ~clk;

  strobe_latch_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .oe_n(oe_n), .rw(rw),
    .strb_n(strb_n), .sys_reg(sys_reg), .mon_reg(mon_reg), .clk_reg(clk_reg),
    .rate_idx(rate_idx), .clk_src(clk_src), .cfg_invalid(cfg_invalid)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // Expected decode, restated as arithmetic on the byte.
  function automatic int exp_src(input logic [7:0] v);
    int low5 = int'(v) % 32;
    if ((v & 8'h08) == 0) return 0;
    if (low5 == 8)  return 1;
    if (low5 == 10) return 2;
    if (low5 == 26) return 3;
    return 0;
  endfunction

  function automatic int exp_rate(input logic [7:0] v);
    return ((v & 8'h08) == 0) ? int'(v) % 8 : 0;
  endfunction

  function automatic int exp_bad(input logic [7:0] v);
    if ((v & 8'h08) == 0) return (int'(v) % 8 >= 6) ? 1 : 0;
    return (exp_src(v) == 0) ? 1 : 0;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic access(input logic [2:0] sel, input logic [7:0] v,
                        input logic rwv, input logic oev);
    @(negedge clk);
    bus_d = v; rw = rwv;
    cyc(2);
    oe_n = oev;
    cyc(2);
    strb_n = ~sel;
    cyc(3);
    strb_n = 3'b111;
    cyc(3);
    bus_d = 8'hFF; oe_n = 1'b1; rw = 1'b0;
    cyc(3);
    if (!rwv && !oev)
      for (int i = 0; i < 3; i++) if (sel[i]) exp_r[i] = v;
  endtask

  task automatic check_all(input string tag);
    chk({tag, " sys"}, sys_reg, exp_r[0]);
    chk({tag, " mon"}, mon_reg, exp_r[1]);
    chk({tag, " clk"}, clk_reg, exp_r[2]);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) exp_r[i] = 8'h00;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    check_all("R1 reset");
    chk("R1 src", clk_src, 0);
    chk("R1 rate", rate_idx, 0);
    chk("R1 invalid", cfg_invalid, 0);

    // R2 / R10: system and monitor patterns
    access(3'b001, 8'hA5, 1'b0, 1'b0); check_all("R2 sys A5");
    access(3'b001, 8'hFF, 1'b0, 1'b0); check_all("R10 sys FF");
    for (int b = 0; b < 8; b++) begin
      access(3'b010, 8'(1 << b), 1'b0, 1'b0); check_all("R2 mon walk");
    end

    // R2 latency: new value appears on the 3rd rising edge after release
    @(negedge clk);
    bus_d = 8'h3C; cyc(2); oe_n = 1'b0; cyc(2); strb_n = 3'b110; cyc(3);
    strb_n = 3'b111;
    cyc(2);
    chk("R2 not before 3rd edge", sys_reg, exp_r[0]);
    cyc(1);
    exp_r[0] = 8'h3C;
    chk("R2 at 3rd edge", sys_reg, 8'h3C);
    bus_d = 8'hFF; oe_n = 1'b1; cyc(3);

    // R3 read and R4 disabled enable
    access(3'b111, 8'h11, 1'b1, 1'b0); check_all("R3 read ignored");
    access(3'b111, 8'h22, 1'b0, 1'b1); check_all("R4 oe high ignored");

    // R5: strobe held low, bus changes; falling edge writes nothing
    @(negedge clk);
    bus_d = 8'h55; cyc(2); oe_n = 1'b0; cyc(2); strb_n = 3'b101; cyc(6);
    check_all("R5 low strobe no write");
    bus_d = 8'h69; cyc(4);
    check_all("R5 bus change while low");
    strb_n = 3'b111; cyc(3);
    bus_d = 8'hFF; oe_n = 1'b1; cyc(3);
    exp_r[1] = 8'h69;
    check_all("R5 captures value at release");

    // R9 simultaneous strobes
    access(3'b111, 8'h5A, 1'b0, 1'b0); check_all("R9 all three");
    chk("R9 src", clk_src, 3);

    // R6 R7 R8 R10: full clock register sweep
    for (int v = 0; v < 256; v++) begin
      access(3'b100, 8'(v), 1'b0, 1'b0);
      chk("R10 clk byte", clk_reg, v);
      chk("R6 rate", rate_idx, exp_rate(8'(v)));
      chk("R7 src", clk_src, exp_src(8'(v)));
      chk("R8 invalid", cfg_invalid, exp_bad(8'(v)));
    end
    check_all("R5 others untouched");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule